// File: doc/BRIEF.md
# NAND Read Command and Address Sequencer

This block turns a single read request from a host into the ordered list of command and address cycles that a raw 8-bit parallel NAND flash expects. Every bus cycle puts one byte on the I/O lines with either the command latch or the address latch raised. The write strobe is pulsed low for a configurable number of clocks, and chip enable is held low for the whole sequence.

Two operations are offered. A page read sends the setup command, the column offset, the row (page) address and then the read-start confirm. A change of read column within a page already sitting in the device's buffer sends only the column bytes between its two commands. Row bytes must never appear in that case, because some devices misbehave when they do. A per-request option adds a fifth address byte for larger devices.

The block stops once the last command cycle has gone out. Data transfer, ready/busy polling, error correction, program and erase belong to other logic.

Top module: `nand_rd_seq`

## Requirements
- R1: A column-change request (op = 1) produces exactly four bus cycles: 05h with command latch, column low byte with address latch, column high byte with address latch, E0h with command latch. No page-address byte appears, whatever page value the request carries.
- R2: A page read (op = 0) produces, in order: 00h with command latch, two column bytes, the row bytes, then 30h with command latch.
- R3: Column bytes go out low first: col[7:0], then col[15:8].
- R4: Row bytes are page[7:0] and then page[15:8]. When the five-cycle flag is set, a third row byte {4'h0, page[19:16]} follows. When it is clear, there are exactly two row bytes.
- R5: Each bus cycle holds the write strobe low for HOLD clocks and then high for one clock. The I/O byte and both latch enables stay constant across the cycle, and exactly one of the two latch enables is high.
- R6: Chip enable is low from the first clock of the first cycle to the last clock of the final cycle, and high whenever the block is idle. In idle, both latch enables are low, the strobe is high and the I/O byte is 00h.
- R7: `done` is high for exactly one clock, the clock right after the last bus cycle ends, with the block already idle.
- R8: `req_ready` is high only while idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. A request held valid while busy waits, and is taken in the same clock that `done` is high.
- R9: While reset is active, and just after it, chip enable and the strobe are high, both latches are low, `req_ready` is high and `done` is low.
- R10: The operation, column, page and five-cycle flag are captured when a request is taken. Changes on those inputs during the sequence do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 1 | 0 = page read, 1 = change read column |
| req_col | input | 16 | Column offset within the page |
| req_page | input | 20 | Page (row) address |
| req_five | input | 1 | Send a third row byte (five address cycles) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Byte on the flash I/O lines |
| done | output | 1 | One-clock pulse after the final cycle |

## Verification
Several properties are checked on every clock by the assertions. Chip enable high and `done` occur only while the block is idle. The two latch enables are mutually exclusive and never both low during a sequence. The byte and the latches hold still when the strobe rises, and `done` never lasts two clocks. Only the bench's cycle-accurate reference can show that the byte list is right for each operation and flag, including the absence of row bytes on a column change and the exact placement of the fifth byte. The same holds for the strobe timing, the capture of inputs at acceptance, and the timing of a request that waits while the block is busy.

// File: rtl/nand_rd_seq.sv
module nand_rd_seq #(
  parameter int HOLD = 2,
  parameter logic [7:0] CMD_READ   = 8'h00,
  parameter logic [7:0] CMD_START  = 8'h30,
  parameter logic [7:0] CMD_RND    = 8'h05,
  parameter logic [7:0] CMD_RNDEND = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_op,
  input  logic [15:0] req_col,
  input  logic [19:0] req_page,
  input  logic        req_five,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic [7:0]  nand_io,
  output logic        done
);
  localparam int PH_W = $clog2(HOLD + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HOLD);

  logic            busy, done_q;
  logic [2:0]      idx;
  logic [PH_W-1:0] ph;
  logic            op_q, five_q;
  logic [15:0]     col_q;
  logic [19:0]     page_q;

  logic       step_cmd;
  logic [7:0] step_byte;
  logic [2:0] last_idx;

  assign last_idx = op_q ? 3'd3 : (five_q ? 3'd6 : 3'd5);

  always_comb begin
    step_cmd  = 1'b0;
    step_byte = 8'h00;
    case (idx)
      3'd0: begin step_cmd = 1'b1; step_byte = op_q ? CMD_RND : CMD_READ; end
      3'd1: step_byte = col_q[7:0];
      3'd2: step_byte = col_q[15:8];
      3'd3: begin
        step_cmd  = op_q;
        step_byte = op_q ? CMD_RNDEND : page_q[7:0];
      end
      3'd4: step_byte = page_q[15:8];
      3'd5: begin
        step_cmd  = !five_q;
        step_byte = five_q ? {4'h0, page_q[19:16]} : CMD_START;
      end
      default: begin step_cmd = 1'b1; step_byte = CMD_START; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      idx    <= '0;
      ph     <= '0;
      op_q   <= 1'b0;
      five_q <= 1'b0;
      col_q  <= '0;
      page_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          idx    <= '0;
          ph     <= '0;
          op_q   <= req_op;
          five_q <= req_five;
          col_q  <= req_col;
          page_q <= req_page;
        end
      end else if (ph != PH_LAST) begin
        ph <= ph + 1'b1;
      end else begin
        ph <= '0;
        if (idx == last_idx) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign req_ready = !busy;
  assign done      = done_q;
  assign nand_ce_n = !busy;
  assign nand_cle  = busy && step_cmd;
  assign nand_ale  = busy && !step_cmd;
  assign nand_we_n = !(busy && ph != PH_LAST);
  assign nand_io   = busy ? step_byte : 8'h00;
endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic [7:0] nand_io,
  input logic       done
);
  a_r5_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> (nand_cle ^ nand_ale));

  a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale)));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (!nand_cle && !nand_ale && nand_we_n));

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && nand_ce_n));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!nand_ce_n));
endmodule

bind nand_rd_seq nand_rd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_io(nand_io), .done(done)
);

// File: tb/tb_nand_rd_seq.sv
module tb_nand_rd_seq;
  localparam int HOLD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, req_five = 1'b0;
  logic [15:0] req_col = '0;
  logic [19:0] req_page = '0;
  logic req_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, done;
  logic [7:0] nand_io;

  always #5 clk = ~clk;

  nand_rd_seq #(.HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_page(req_page), .req_five(req_five),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_io(nand_io), .done(done)
  );

  typedef struct {
    logic ce_n, cle, ale, we_n, ready, dn;
    logic [7:0] io;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  function automatic void push_cycle(logic cmd, logic [7:0] b, string tag);
    for (int i = 0; i <= HOLD; i++) begin
      exp_t e;
      e.ce_n = 1'b0; e.cle = cmd; e.ale = !cmd; e.we_n = (i == HOLD);
      e.ready = 1'b0; e.dn = 1'b0; e.io = b; e.tag = tag;
      q.push_back(e);
    end
  endfunction

  function automatic void push_seq(logic op, logic [15:0] col, logic [19:0] page, logic five);
    exp_t e;
    if (op) begin
      push_cycle(1'b1, 8'h05, "R1");
      push_cycle(1'b0, col[7:0], "R1/R3");
      push_cycle(1'b0, col[15:8], "R1/R3");
      push_cycle(1'b1, 8'hE0, "R1");
    end else begin
      push_cycle(1'b1, 8'h00, "R2");
      push_cycle(1'b0, col[7:0], "R2/R3");
      push_cycle(1'b0, col[15:8], "R2/R3");
      push_cycle(1'b0, page[7:0], "R4");
      push_cycle(1'b0, page[15:8], "R4");
      if (five) push_cycle(1'b0, {4'h0, page[19:16]}, "R4");
      push_cycle(1'b1, 8'h30, "R2");
    end
    e.ce_n = 1'b1; e.cle = 1'b0; e.ale = 1'b0; e.we_n = 1'b1;
    e.ready = 1'b1; e.dn = 1'b1; e.io = 8'h00; e.tag = "R7";
    q.push_back(e);
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!finished) begin
      cycles++;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.ce_n = 1'b1; e.cle = 1'b0; e.ale = 1'b0; e.we_n = 1'b1;
        e.ready = 1'b1; e.dn = 1'b0; e.io = 8'h00;
        e.tag = rst_n ? "R6" : "R9";
      end
      chk(e.tag, "io", nand_io, e.io);
      chk(e.tag, "cle", {7'b0, nand_cle}, {7'b0, e.cle});
      chk(e.tag, "ale", {7'b0, nand_ale}, {7'b0, e.ale});
      chk("R5", "we_n", {7'b0, nand_we_n}, {7'b0, e.we_n});
      chk("R6", "ce_n", {7'b0, nand_ce_n}, {7'b0, e.ce_n});
      chk("R7", "done", {7'b0, done}, {7'b0, e.dn});
      chk("R8", "ready", {7'b0, req_ready}, {7'b0, e.ready});
      if (rst_n && e.ready && req_valid) push_seq(req_op, req_col, req_page, req_five);
    end
  end

  task automatic send(logic op, logic [15:0] col, logic [19:0] page, logic five, bit keep);
    logic acc;
    req_valid = 1'b1; req_op = op; req_col = col; req_page = page; req_five = five;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    if (!keep) begin
      req_valid = 1'b0;
      req_op = ~op; req_col = ~col; req_page = ~page; req_five = ~five; // R10 scramble
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2);
    send(1'b1, 16'h0834, 20'hABCDE, 1'b1, 0);  // R1 page given but ignored
    idle(30);
    send(1'b0, 16'h1F2E, 20'h9A5C3, 1'b1, 0);  // R2 R4 five cycles
    idle(30);
    send(1'b0, 16'h00FF, 20'h71234, 1'b0, 0);  // R4 four cycles
    idle(30);
    send(1'b1, 16'hFFFF, 20'h00000, 1'b0, 0);  // R3
    send(1'b0, 16'h8001, 20'hFFFFF, 1'b1, 0);  // R8 waits while busy
    idle(40);
    send(1'b0, 16'h3C3C, 20'h5A5A5, 1'b0, 1);  // R8 back to back
    send(1'b1, 16'h1234, 20'h54321, 1'b1, 0);
    idle(40);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule